// File: doc/BRIEF.md
# Periodic Wake-Up Interrupt Timer

This block counts slow timebase ticks against a programmable 32-bit period and raises an interrupt each time a full period has elapsed. Software sets the period through a byte-wide register port. It writes the three upper period bytes first. The final write, to the least-significant byte, moves all four bytes into the active compare register at once and restarts the count from zero. A period of zero stops the timer.

The running count can be read over the same port as four bytes. Reading the lowest count byte returns its live value and also freezes the whole count in a snapshot. Reads of the three upper count bytes then return bytes from that snapshot, so the four bytes belong to the same instant. The interrupt path has three parts: a pending flag that any period match sets, an enable bit that gates the output pin, and a write-one-to-clear bit.

The register port carries no stream traffic and has no back-pressure. It accepts a write or a read in every cycle. Read data appears, qualified by a valid strobe, one cycle after the read request.

Top module: `wake_timer`

## Requirements
- R1: After reset, all period bytes (staged and active), the counter, the pending flag and the enable bit are zero, and `irq` is low.
- R2: Period bytes sit at 0x00 (most significant) to 0x03 (least significant) and read back their staged value. A write to 0x00, 0x01 or 0x02 changes only the staged byte. The active period keeps its old value.
- R3: A write to 0x03 loads the active period with the three staged upper bytes and the written byte, and clears the counter to zero. If a tick arrives in the same cycle, the restart wins.
- R4: While the active period is zero the counter stays at zero and no match occurs.
- R5: With a non-zero period P, each tick raises the counter by one. A tick that arrives while the counter is at P-1 returns it to zero and produces a match, so a match occurs once every P ticks.
- R6: A read of 0x07 returns the counter's low byte and captures the whole counter. Reads of 0x04 (most significant), 0x05 and 0x06 return bytes of the last capture, not the live counter.
- R7: A match sets the pending flag, which reads as bit 1 of status register 0x1A, whether or not the interrupt is enabled.
- R8: Bit 0 of config register 0x0E is the interrupt enable, and `irq` is high exactly when pending and enable are both 1. Config reads return the enable in bit 0 and 0 in bit 1.
- R9: A config write with bit 1 set clears the pending flag. A config write with bit 1 clear leaves the flag unchanged.
- R10: When a match and a clearing config write fall in the same cycle, the pending flag ends up set.
- R11: `rd_valid` is high in the cycle after each `rd_en` and carries that read's data on `rdata`. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per timebase period (32.768 kHz) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 8 | Read data |
| irq | output | 1 | Interrupt output, pending AND enable |

## Verification
A table of periods and tick counts drives the main counting path, and each row reads back the counter and the pending flag. The rows separate a partial period, an exact period, a wrap past a period, a period of one that matches on every tick, a zero period, and periods whose non-zero bytes sit above the low byte. Directed sequences then test the remaining behaviours: staging without a commit, enable gating, a write of zero to the clear bit, and a match that collides with a clear. They also test a restart that collides with a tick, and a snapshot read taken after the counter has moved on, which shows that the upper bytes come from the capture and not from the live counter.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_PER_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] A_TMR_BASE = 8'h04;
  localparam logic [ADDR_W-1:0] A_CFG      = 8'h0E;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h1A;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_CLR_BIT   = 1;
  localparam int STAT_PEND_BIT = 1;
endpackage

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  stage,
  output logic [CNT_W-1:0]  active,
  output logic              commit,
  output logic              clr,
  output logic              en
);
  localparam int NB = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] PER_LSB = ADDR_W'(int'(A_PER_BASE) + NB - 1);

  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] active_q;
  logic             en_q;
  logic             cfg_wr;

  assign commit = wr_en && (addr == PER_LSB);
  assign cfg_wr = wr_en && (addr == A_CFG);
  assign clr    = cfg_wr && wdata[CFG_CLR_BIT];

  // staging bytes: byte k at base+k, k=0 is most significant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int k = 0; k < NB; k++) begin
        if (wr_en && (addr == ADDR_W'(int'(A_PER_BASE) + k)))
          stage_q[(NB-1-k)*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= '0;
    else if (commit) active_q <= {stage_q[CNT_W-1:DATA_W], wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_wr) en_q <= wdata[CFG_EN_BIT];
  end

  assign stage  = stage_q;
  assign active = active_q;
  assign en     = en_q;

  AST_STAGE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit) |=> $stable(active_q)); // R2
  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q[DATA_W-1:0] == $past(wdata))); // R3
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;
  logic             at_end;

  assign run    = tick && (period != '0) && !restart;
  assign at_end = (cnt_q == period - CNT_W'(1));
  assign match  = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R3
  AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> (cnt_q == '0 && !match)); // R4
  AST_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (cnt_q < period)); // R5
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
endmodule

// File: rtl/wkt_irq.sv
module wkt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic en,
  output logic pending,
  output logic irq
);
  logic pend_q;

  // a match outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (match) pend_q <= 1'b1;
    else if (clr)   pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign irq     = pend_q && en;

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !pend_q); // R9
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq); // R8
endmodule

// File: rtl/wkt_readout.sv
module wkt_readout
  import wkt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  stage,
  input  logic              en,
  input  logic              pending,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] TMR_LSB = ADDR_W'(int'(A_TMR_BASE) + NB - 1);

  logic [CNT_W-1:DATA_W] snap_q;
  logic [DATA_W-1:0]     rd_byte;
  logic [DATA_W-1:0]     rdata_q;
  logic                  valid_q;
  logic                  grab;

  assign grab = rd_en && (addr == TMR_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (grab) snap_q <= cnt[CNT_W-1:DATA_W];
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr == ADDR_W'(int'(A_PER_BASE) + k))
        rd_byte = stage[(NB-1-k)*DATA_W +: DATA_W];
      if (addr == ADDR_W'(int'(A_TMR_BASE) + k)) begin
        if (k == NB - 1) rd_byte = cnt[DATA_W-1:0];
        else             rd_byte = snap_q[(NB-1-k)*DATA_W +: DATA_W];
      end
    end
    if (addr == A_CFG) begin
      rd_byte = '0;
      rd_byte[CFG_EN_BIT] = en;
    end
    if (addr == A_STAT) begin
      rd_byte = '0;
      rd_byte[STAT_PEND_BIT] = pending;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= rd_en;
      rdata_q <= rd_en ? rd_byte : '0;
    end
  end

  assign rd_valid = valid_q;
  assign rdata    = rdata_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R11
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> (snap_q == $past(cnt[CNT_W-1:DATA_W]))); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !grab |=> $stable(snap_q)); // R6
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wkt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [CNT_W-1:0] stage;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic             commit;
  logic             clr;
  logic             en;
  logic             match;
  logic             pending;

  wkt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stage(stage), .active(period), .commit(commit), .clr(clr), .en(en)
  );

  wkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(commit),
    .period(period), .cnt(cnt), .match(match)
  );

  wkt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .match(match), .clr(clr), .en(en),
    .pending(pending), .irq(irq)
  );

  wkt_readout #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cnt(cnt),
    .stage(stage), .en(en), .pending(pending),
    .rd_valid(rd_valid), .rdata(rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> en); // R8
endmodule

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NV = 7;
  localparam logic [31:0] VP [NV] = '{32'd5, 32'd5, 32'd5, 32'd1, 32'd0, 32'h0001_0000, 32'h100};
  localparam int          VT [NV] = '{3, 5, 7, 4, 10, 300, 256};
  localparam logic [31:0] VC [NV] = '{32'd3, 32'd0, 32'd2, 32'd0, 32'd0, 32'd300, 32'd0};
  localparam logic        VQ [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic rd_valid, irq;
  logic [7:0] rdata;

  int nchk = 0, nerr = 0, cyc = 0;
  logic done = 1'b0;

  wake_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rdata;
    check("R11 rd_valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_period(input logic [31:0] p);
    wr(8'h00, p[31:24]); wr(8'h01, p[23:16]); wr(8'h02, p[15:8]); wr(8'h03, p[7:0]);
  endtask

  task automatic read_cnt(output logic [31:0] c);
    logic [7:0] b;
    rd(8'h07, b); c[7:0] = b;
    rd(8'h04, b); c[31:24] = b;
    rd(8'h05, b); c[23:16] = b;
    rd(8'h06, b); c[15:8] = b;
  endtask

  task automatic read_pend(output logic p);
    logic [7:0] b;
    rd(8'h1A, b); p = b[1];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      nerr++;
      $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [31:0] c;
    logic p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rd_valid idle", 32'(rd_valid), 32'd0);
    for (int k = 0; k < 4; k++) begin
      rd(8'(k), b); check("R1 period byte", 32'(b), 32'd0);
    end
    read_cnt(c); check("R1 counter", c, 32'd0);
    read_pend(p); check("R1 pending", 32'(p), 32'd0);
    rd(8'h0E, b); check("R1 config", 32'(b), 32'd0);

    // table of period / tick count vectors (R3 R4 R5 R7)
    for (int v = 0; v < NV; v++) begin
      set_period(VP[v]);
      wr(8'h0E, 8'h02);
      ticks(VT[v]);
      read_cnt(c);   check("R5 counter after ticks", c, VC[v]);
      read_pend(p);  check("R7 pending after ticks", 32'(p), 32'(VQ[v]));
      check("R8 irq stays low while disabled", 32'(irq), 32'd0);
    end

    // R2 staging without commit
    set_period(32'd4);
    wr(8'h0E, 8'h02);
    ticks(2);
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h02, 8'hFF);
    rd(8'h01, b); check("R2 staged byte readback", 32'(b), 32'hFF);
    ticks(2);
    read_cnt(c);  check("R2 old period still active", c, 32'd0);
    read_pend(p); check("R2 match at old period", 32'(p), 32'd1);

    // R8 / R9 enable and clear
    check("R8 irq gated by enable", 32'(irq), 32'd0);
    wr(8'h0E, 8'h01);
    check("R8 irq when enabled", 32'(irq), 32'd1);
    rd(8'h0E, b); check("R8 config readback", 32'(b), 32'h01);
    wr(8'h0E, 8'h01);
    read_pend(p); check("R9 clear bit zero no effect", 32'(p), 32'd1);
    wr(8'h0E, 8'h03);
    read_pend(p); check("R9 clear drops pending", 32'(p), 32'd0);
    check("R9 irq low after clear", 32'(irq), 32'd0);
    rd(8'h0E, b); check("R8 clear bit reads zero", 32'(b), 32'h01);

    // R10 match collides with clear
    set_period(32'd2);
    ticks(3);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 8'h0E; wdata = 8'h03;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    read_pend(p); check("R10 match beats clear", 32'(p), 32'd1);
    read_cnt(c);  check("R10 counter wrapped", c, 32'd0);

    // R3 restart collides with tick
    ticks(1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 8'h03; wdata = 8'h02;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    read_cnt(c); check("R3 restart beats tick", c, 32'd0);

    // R6 snapshot coherence
    set_period(32'h0001_0000);
    ticks(511);
    rd(8'h07, b); check("R6 live low byte", 32'(b), 32'hFF);
    ticks(1);
    rd(8'h06, b); check("R6 upper byte from snapshot", 32'(b), 32'h01);
    rd(8'h07, b); check("R6 new low byte", 32'(b), 32'h00);
    rd(8'h06, b); check("R6 refreshed snapshot", 32'(b), 32'h02);

    // R11 unmapped read
    rd(8'h10, b); check("R11 unmapped reads zero", 32'(b), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule